// File: doc/BRIEF.md
# Register Rename Map Table

This block holds the speculative mapping from architectural register numbers to physical register numbers in an out-of-order core. One flat architectural number space is divided into three regions. The lowest numbers are integer registers, the next block is floating-point registers, and everything above both is a miscellaneous register. Integer and floating-point registers are renamed from two free lists held inside the block. Miscellaneous registers sit at a fixed offset and are never renamed. One integer register is the hard-wired zero register, and renaming it has no effect.

A rename request names a destination register. One cycle after it is accepted, the block returns the newly allocated physical register and the mapping it replaced. A combinational lookup port resolves source operands. A set-entry port lets recovery logic overwrite a mapping. A release port hands old physical registers back to the free lists. The block also reports how many renames can still be guaranteed. With the defaults, architectural registers 0..7 are integer, 8..15 are floating-point and 16..19 are miscellaneous. Physical registers 0..15 are integer, 16..31 are floating-point and 32..35 are miscellaneous.

Top module: `rename_map_table`

## Requirements
- R1: After reset, integer register i looks up to physical i. Floating-point register N_INT_LOG+j looks up to physical N_INT_PHYS+j. The integer free list holds N_INT_LOG..N_INT_PHYS-1 in ascending order. The floating-point list holds N_INT_PHYS+N_FP_LOG..N_INT_PHYS+N_FP_PHYS-1 in ascending order.
- R2: An accepted rename of a non-zero integer register returns the old mapping on rn_prev. It returns the head of the integer free list on rn_new. From the next cycle on, lookup of that register shows the new mapping.
- R3: A rename of register INT_ZERO returns INT_ZERO on both rn_new and rn_prev. It consumes no free-list entry and leaves the table unchanged.
- R4: A floating-point rename takes the head of the floating-point free list. That head lies in [N_INT_PHYS, N_INT_PHYS+N_FP_PHYS). rn_prev carries the old mapping, and the table is updated.
- R5: For a miscellaneous register a, both rename outputs and lookup give a - (N_INT_LOG+N_FP_LOG) + (N_INT_PHYS+N_FP_PHYS).
- R6: A set-entry with an integer or floating-point index overwrites that mapping. A set-entry with a miscellaneous index changes nothing.
- R7: free_count equals the smaller of the two free-list occupancies.
- R8: rn_ready is low for an integer (non-zero) or floating-point request whose free list is empty. A request made while rn_ready is low changes neither the table nor the outputs.
- R9: A released register is appended to the tail of the list whose physical range contains it. A release is dropped if it is outside both ranges, equals INT_ZERO, or arrives while that list is full.
- R10: A lookup in the same cycle as a rename of the same register returns the mapping from before the rename.
- R11: While se_valid is high, rn_ready is low, so recovery writes always take priority.
- R12: rn_done pulses exactly one cycle after each accepted rename and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rn_valid | input | 1 | Rename request |
| rn_arch | input | AW | Destination architectural register |
| rn_ready | output | 1 | Request can be accepted this cycle |
| rn_done | output | 1 | Rename result valid |
| rn_new | output | PW | Newly mapped physical register |
| rn_prev | output | PW | Previous physical register |
| lk_arch | input | AW | Source lookup index |
| lk_phys | output | PW | Current mapping of lk_arch |
| se_valid | input | 1 | Set-entry write |
| se_arch | input | AW | Set-entry architectural index |
| se_phys | input | PW | Set-entry physical value |
| rel_valid | input | 1 | Release a physical register |
| rel_phys | input | PW | Released physical register |
| free_count | output | CW | Minimum of the free-list occupancies |

## Verification
Several properties are checked on every cycle. The fixed pairing of outputs for zero-register and miscellaneous renames is always true, and floating-point results always fall in their physical range. rn_done follows acceptance by exactly one cycle. A free list is never popped while empty and never holds more than its capacity. Other behaviour only shows up in the bench scenarios. These scenarios cover the FIFO order of allocation and of reuse after a release, and the table contents seen through lookup after renames and set-entries. They also cover dropped releases, the value of free_count as the lists drain and refill, and the same-cycle lookup returning the old mapping.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  typedef enum logic [1:0] {
    RGN_INT  = 2'd0,
    RGN_FP   = 2'd1,
    RGN_MISC = 2'd2
  } region_e;

  function automatic region_e classify(input int idx, input int n_int, input int n_fp);
    if (idx < n_int) return RGN_INT;
    else if (idx < n_int + n_fp) return RGN_FP;
    else return RGN_MISC;
  endfunction
endpackage

// File: rtl/rmt_free_list.sv
module rmt_free_list #(
  parameter int PW         = 6,
  parameter int CW         = 4,
  parameter int LO         = 0,
  parameter int HI         = 15,
  parameter int FIRST_FREE = 8,
  parameter bit HAS_SKIP   = 1'b0,
  parameter int SKIP_IDX   = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_data,
  output logic [PW-1:0] head,
  output logic [CW-1:0] count
);
  localparam int DEPTH = HI - FIRST_FREE + 1;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] mem [DEPTH];
  logic [IW-1:0] rd_ptr, wr_ptr;
  logic          in_range, take;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    in_range = (int'(push_data) >= LO) && (int'(push_data) <= HI);
    if (HAS_SKIP && int'(push_data) == SKIP_IDX) in_range = 1'b0;
    take = push && in_range && ((int'(count) < DEPTH) || pop);
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= PW'(FIRST_FREE + i);
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= CW'(DEPTH);
    end else begin
      if (take) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      if (take && !pop)      count <= count + 1'b1;
      else if (pop && !take) count <= count - 1'b1;
    end
  end

  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
  p_capacity_r9: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);
  p_head_range_r4: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |-> (int'(head) >= LO && int'(head) <= HI));
endmodule

// File: rtl/rmt_map_ram.sv
module rmt_map_ram #(
  parameter int N_INT_LOG = 8,
  parameter int N_FP_LOG  = 8,
  parameter int FP_BASE   = 16,
  parameter int TW        = 4,
  parameter int PW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [TW-1:0] wa,
  input  logic [PW-1:0] wd,
  input  logic [TW-1:0] ra0,
  output logic [PW-1:0] rd0,
  input  logic [TW-1:0] ra1,
  output logic [PW-1:0] rd1
);
  localparam int N = N_INT_LOG + N_FP_LOG;

  logic [PW-1:0] tbl [N];

  assign rd0 = (int'(ra0) < N) ? tbl[ra0] : '0;
  assign rd1 = (int'(ra1) < N) ? tbl[ra1] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++)
        tbl[i] <= (i < N_INT_LOG) ? PW'(i) : PW'(FP_BASE + i - N_INT_LOG);
    end else if (we && int'(wa) < N) begin
      tbl[wa] <= wd;
    end
  end
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rmt_pkg::*;
#(
  parameter int N_INT_LOG  = 8,
  parameter int N_FP_LOG   = 8,
  parameter int N_MISC     = 4,
  parameter int N_INT_PHYS = 16,
  parameter int N_FP_PHYS  = 16,
  parameter int INT_ZERO   = 0,
  localparam int N_LOG     = N_INT_LOG + N_FP_LOG,
  localparam int N_PHYS    = N_INT_PHYS + N_FP_PHYS,
  localparam int AW        = $clog2(N_LOG + N_MISC),
  localparam int PW        = $clog2(N_PHYS + N_MISC),
  localparam int INT_DEPTH = N_INT_PHYS - N_INT_LOG,
  localparam int FP_DEPTH  = N_FP_PHYS - N_FP_LOG,
  localparam int MAXD      = (INT_DEPTH > FP_DEPTH) ? INT_DEPTH : FP_DEPTH,
  localparam int CW        = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rn_valid,
  input  logic [AW-1:0] rn_arch,
  output logic          rn_ready,
  output logic          rn_done,
  output logic [PW-1:0] rn_new,
  output logic [PW-1:0] rn_prev,
  input  logic [AW-1:0] lk_arch,
  output logic [PW-1:0] lk_phys,
  input  logic          se_valid,
  input  logic [AW-1:0] se_arch,
  input  logic [PW-1:0] se_phys,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_phys,
  output logic [CW-1:0] free_count
);
  localparam int TW = $clog2(N_LOG);

  region_e       rn_rgn, lk_rgn;
  logic          rn_zero, accept, int_pop, fp_pop;
  logic [CW-1:0] int_cnt, fp_cnt;
  logic [PW-1:0] int_head, fp_head, tbl_rn, tbl_lk, rn_misc, lk_misc;
  logic          tbl_we;
  logic [TW-1:0] tbl_wa;
  logic [PW-1:0] tbl_wd;

  function automatic logic [PW-1:0] misc_map(input logic [AW-1:0] a);
    return PW'(a) + PW'(N_PHYS - N_LOG);
  endfunction

  always_comb begin
    rn_rgn  = classify(int'(rn_arch), N_INT_LOG, N_FP_LOG);
    lk_rgn  = classify(int'(lk_arch), N_INT_LOG, N_FP_LOG);
    rn_zero = (rn_rgn == RGN_INT) && (int'(rn_arch) == INT_ZERO);
    rn_misc = misc_map(rn_arch);
    lk_misc = misc_map(lk_arch);
    case (rn_rgn)
      RGN_INT: rn_ready = rn_zero || (int_cnt != '0);
      RGN_FP:  rn_ready = (fp_cnt != '0);
      default: rn_ready = 1'b1;
    endcase
    if (se_valid) rn_ready = 1'b0;
    accept  = rn_valid && rn_ready;
    int_pop = accept && (rn_rgn == RGN_INT) && !rn_zero;
    fp_pop  = accept && (rn_rgn == RGN_FP);
    if (se_valid) begin
      tbl_we = (int'(se_arch) < N_LOG);
      tbl_wa = TW'(se_arch);
      tbl_wd = se_phys;
    end else begin
      tbl_we = int_pop || fp_pop;
      tbl_wa = TW'(rn_arch);
      tbl_wd = int_pop ? int_head : fp_head;
    end
    lk_phys    = (lk_rgn == RGN_MISC) ? lk_misc : tbl_lk;
    free_count = (int_cnt < fp_cnt) ? int_cnt : fp_cnt;
  end

  rmt_map_ram #(
    .N_INT_LOG(N_INT_LOG), .N_FP_LOG(N_FP_LOG), .FP_BASE(N_INT_PHYS),
    .TW(TW), .PW(PW)
  ) u_map (
    .clk(clk), .rst(rst), .we(tbl_we), .wa(tbl_wa), .wd(tbl_wd),
    .ra0(TW'(rn_arch)), .rd0(tbl_rn), .ra1(TW'(lk_arch)), .rd1(tbl_lk)
  );

  rmt_free_list #(
    .PW(PW), .CW(CW), .LO(0), .HI(N_INT_PHYS - 1), .FIRST_FREE(N_INT_LOG),
    .HAS_SKIP(1'b1), .SKIP_IDX(INT_ZERO)
  ) u_int_fl (
    .clk(clk), .rst(rst), .pop(int_pop), .push(rel_valid), .push_data(rel_phys),
    .head(int_head), .count(int_cnt)
  );

  rmt_free_list #(
    .PW(PW), .CW(CW), .LO(N_INT_PHYS), .HI(N_PHYS - 1),
    .FIRST_FREE(N_INT_PHYS + N_FP_LOG), .HAS_SKIP(1'b0), .SKIP_IDX(0)
  ) u_fp_fl (
    .clk(clk), .rst(rst), .pop(fp_pop), .push(rel_valid), .push_data(rel_phys),
    .head(fp_head), .count(fp_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rn_done <= 1'b0;
      rn_new  <= '0;
      rn_prev <= '0;
    end else begin
      rn_done <= accept;
      if (accept) begin
        case (rn_rgn)
          RGN_INT: begin
            rn_new  <= rn_zero ? PW'(INT_ZERO) : int_head;
            rn_prev <= rn_zero ? PW'(INT_ZERO) : tbl_rn;
          end
          RGN_FP: begin
            rn_new  <= fp_head;
            rn_prev <= tbl_rn;
          end
          default: begin
            rn_new  <= rn_misc;
            rn_prev <= rn_misc;
          end
        endcase
      end
    end
  end

  p_zero_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && rn_zero) |=> (rn_new == PW'(INT_ZERO) && rn_prev == PW'(INT_ZERO)));
  p_misc_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && rn_rgn == RGN_MISC) |=> (rn_new == rn_prev && int'(rn_new) >= N_PHYS));
  p_fp_range_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && rn_rgn == RGN_FP) |=> (int'(rn_new) >= N_INT_PHYS && int'(rn_new) < N_PHYS));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    (rn_valid && rn_ready) |=> rn_done);
  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !(rn_valid && rn_ready) |=> !rn_done);
  p_recovery_first_r11: assert property (@(posedge clk) disable iff (rst)
    se_valid |-> !(int_pop || fp_pop));
endmodule

// File: tb/rename_map_table_tb.sv
module rename_map_table_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic rn_valid = 0, se_valid = 0, rel_valid = 0;
  logic [4:0] rn_arch = '0, lk_arch = '0, se_arch = '0;
  logic [5:0] se_phys = '0, rel_phys = '0;
  logic rn_ready, rn_done;
  logic [5:0] rn_new, rn_prev, lk_phys;
  logic [3:0] free_count;

  int checks = 0, errors = 0;
  int map [20];
  int iq[$], fq[$];

  always #2 clk = ~clk;

  rename_map_table u_dut (
    .clk(clk), .rst(rst), .rn_valid(rn_valid), .rn_arch(rn_arch), .rn_ready(rn_ready),
    .rn_done(rn_done), .rn_new(rn_new), .rn_prev(rn_prev), .lk_arch(lk_arch),
    .lk_phys(lk_phys), .se_valid(se_valid), .se_arch(se_arch), .se_phys(se_phys),
    .rel_valid(rel_valid), .rel_phys(rel_phys), .free_count(free_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int minq();
    return (iq.size() < fq.size()) ? iq.size() : fq.size();
  endfunction

  task automatic lookup_all(input string req);
    for (int a = 0; a < 20; a++) begin
      @(negedge clk); lk_arch = 5'(a); #1;
      chk(req, lk_phys, (a < 16) ? map[a] : a + 16);
    end
  endtask

  task automatic do_rn(input int a, input bit exp_rdy, input string req);
    int en, ep;
    @(negedge clk); rn_valid = 1; rn_arch = 5'(a); lk_arch = 5'(a); #1;
    chk({req, " R8 ready"}, rn_ready, exp_rdy);
    if (a < 16) chk("R10 same-cycle lookup", lk_phys, map[a]);
    en = 0; ep = 0;
    if (exp_rdy) begin
      if (a >= 16) begin en = a + 16; ep = en; end
      else if (a == 0) begin en = 0; ep = 0; end
      else if (a < 8) begin ep = map[a]; en = iq.pop_front(); map[a] = en; end
      else begin ep = map[a]; en = fq.pop_front(); map[a] = en; end
    end
    @(posedge clk); #1; rn_valid = 0;
    chk({req, " R12 done"}, rn_done, exp_rdy);
    if (exp_rdy) begin
      chk({req, " new"}, rn_new, en);
      chk({req, " prev"}, rn_prev, ep);
    end
    chk({req, " lookup after"}, lk_phys, (a < 16) ? map[a] : a + 16);
  endtask

  task automatic do_rel(input int p);
    @(negedge clk); rel_valid = 1; rel_phys = 6'(p);
    @(posedge clk); #1; rel_valid = 0;
    if (p > 0 && p < 16 && iq.size() < 8) iq.push_back(p);
    else if (p >= 16 && p < 32 && fq.size() < 8) fq.push_back(p);
    chk("R9 R7 free_count after release", free_count, minq());
  endtask

  task automatic do_se(input int a, input int p);
    @(negedge clk); se_valid = 1; se_arch = 5'(a); se_phys = 6'(p);
    @(posedge clk); #1; se_valid = 0;
    if (a < 16) map[a] = p;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) map[i] = (i < 8) ? i : 16 + i - 8;
    for (int i = 8; i < 16; i++) iq.push_back(i);
    for (int i = 24; i < 32; i++) fq.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    chk("R12 reset done", rn_done, 0);
    chk("R7 reset free_count", free_count, 8);
    lookup_all("R1 R5 reset lookup");

    for (int a = 16; a < 20; a++) do_rn(a, 1, "R5 misc");
    do_rn(0, 1, "R3 zero");
    chk("R3 zero uses no entry", free_count, 8);

    for (int a = 1; a < 8; a++) do_rn(a, 1, "R2 int");
    do_rn(3, 1, "R2 int again");
    chk("R7 int drained", free_count, 0);
    do_rn(5, 0, "R8 int empty");
    do_rn(0, 1, "R3 zero while empty");
    do_rn(17, 1, "R5 misc while empty");

    do_rel(33);
    do_rel(0);
    do_rel(3);
    do_rel(20);
    do_rn(2, 1, "R9 reuse released");
    do_rel(9);
    do_rel(4);

    for (int a = 8; a < 16; a++) do_rn(a, 1, "R4 fp");
    do_rn(12, 0, "R8 fp empty");
    do_rel(17);
    do_rel(18);
    chk("R7 min", free_count, minq());
    do_rn(12, 1, "R4 fp reuse");

    do_se(4, 11);
    do_se(10, 30);
    do_se(17, 5);
    lookup_all("R6 set-entry lookup");

    @(negedge clk); se_valid = 1; se_arch = 5'd6; se_phys = 6'd13;
    rn_valid = 1; rn_arch = 5'd18; #1;
    chk("R11 ready blocked", rn_ready, 0);
    @(posedge clk); #1; se_valid = 0; rn_valid = 0; map[6] = 13;
    chk("R11 no rename", rn_done, 0);
    lookup_all("R6 R11 final lookup");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule